// File: doc/BRIEF.md
# Video Encoder Control Register Bank

This block holds the control and status registers of a video encoder and makes them reachable from a host over an 8-bit asynchronous parallel port. The port has three strobes: an active-low chip select, a read/write line that is high for reads, and an address-select line. When address-select is low, the port reaches the internal address pointer. When it is high, the port reaches the register that the pointer names. Every data access advances the pointer by one. The pointer stops advancing once it reaches 22h, so a host can stream bytes into consecutive registers with one pointer load. The same saturation lets it repeat accesses on the last caption-control byte without reloading the pointer.

The host strobe is not related to the 27 MHz core clock. The falling and rising edges of chip select are therefore passed through a synchroniser before anything in the core changes. Address-select, read/write and the data byte are captured once the start of the strobe has been synchronised. The write, or the pointer step, takes effect only after the synchronised end of the strobe. Read data is driven onto the port combinationally while the strobe is held.

The bank contains the following registers:
- fixed identification bytes and a revision byte;
- the global, video-output, general and three caption control bytes, which are brought out as core-side control vectors;
- a read-only field number taken from the timing generator;
- a general-purpose register whose behaviour depends on a serial-mode input. In serial mode it mirrors two input pins and drives four output pins continuously. In parallel mode it drives those four pins only while the host is reading that register.

Top module: `ctl_regbank`

## Requirements
- R1: A write with address-select low loads the pointer (low 6 bits of the byte). A data access with address-select high reads or writes the register at the pointer. A read with address-select low returns the pointer.
- R2: After each data access the pointer increases by one while it is below 22h. At 22h it stays at 22h. A pointer access never moves the pointer except by loading it.
- R3: `bus_oe` is high only while `cs_n` is low and `rw` is high, and never during reset. Otherwise the port is released.
- R4: Addresses 00h, 01h and 02h read 97h, 24h and 90h. Address 03h reads the `REV_ID` parameter.
- R5: Reset loads 00h at 04h, 01h at 05h, F2h at 0Fh, 80h at 20h and 21h, and 00h at 22h and 0Eh. While reset is low, `out_en` is low. `out_en` rises at the first clock edge after reset is released.
- R6: Address 06h reads `field_id` in bits 5:3 and zero in the other bits. Writes to 06h have no effect.
- R7: Addresses 07h–0Dh, 10h–1Fh and anything above 22h read 00h. Writes there change no other register.
- R8: In serial mode (`ser_mode`=1), bits 7:6 of 0Eh read the live `gp_in[1:0]`. In parallel mode they read 00. Writes to those bits have no effect.
- R9: Bits 5:2 of 0Eh are stored and appear on `gp_out[3:0]`. In serial mode `gp_out_en` is high continuously after reset. In parallel mode it is high only while a data read of 0Eh is being strobed.
- R10: Bit 1 of 0Eh reads the live `burst_flag`. Bit 0 reads the live active-low `csync_n`. Neither bit can be written.
- R11: A data write reaches the control outputs only after the synchronised release of `cs_n`. Nothing changes while the strobe is held, nor in the first two clock edges after release with a three-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| rw | input | 1 | Host direction, 1 = read, 0 = write |
| a_sel | input | 1 | 0 = pointer access, 1 = register data access |
| bus_in | input | DATA_W | Host write byte |
| bus_out | output | DATA_W | Host read byte |
| bus_oe | output | 1 | Drive enable for the host data port |
| ser_mode | input | 1 | 1 = serial control mode, 0 = parallel |
| gp_in | input | 2 | Live levels of the two general-purpose input pins |
| gp_out | output | 4 | General-purpose output levels |
| gp_out_en | output | 1 | Drive enable for the general-purpose output pins |
| burst_flag | input | 1 | Live burst-flag status from the sync generator |
| csync_n | input | 1 | Live composite sync, low during sync tips |
| field_id | input | 3 | Current field number |
| out_en | output | 1 | Low while reset holds the encoder outputs off |
| glob_ctl | output | 8 | Global control byte (04h) |
| vid_ctl | output | 8 | Video-output control byte (05h) |
| gen_ctl | output | 8 | General control byte (0Fh) |
| cc_byte1 | output | 8 | First caption byte (20h) |
| cc_byte2 | output | 8 | Second caption byte (21h) |
| cc_ctl | output | 8 | Caption control byte (22h) |

## Verification
The bench instantiates the block with a three-stage synchroniser and a revision byte of 3Ah instead of the defaults. With those values, the revision readback is distinguishable from every reset value. The longer synchroniser also widens the window in which a write must not yet be visible, which makes the timing of R11 observable at the ports. The bench also walks the pointer into 22h and beyond, loads it into reserved and unmapped space, and flips `ser_mode` to cover both behaviours of the general-purpose register.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;

   // fixed register locations (6-bit address space)
   localparam logic [5:0] A_ID0   = 6'h00;
   localparam logic [5:0] A_ID1   = 6'h01;
   localparam logic [5:0] A_ID2   = 6'h02;
   localparam logic [5:0] A_REV   = 6'h03;
   localparam logic [5:0] A_FIELD = 6'h06;
   localparam logic [5:0] A_GP    = 6'h0E;
   localparam logic [5:0] A_LAST  = 6'h22;

   // plain read/write control bytes
   localparam int NCTL = 6;
   localparam int C_GLOB = 0;
   localparam int C_VID  = 1;
   localparam int C_GEN  = 2;
   localparam int C_CC1  = 3;
   localparam int C_CC2  = 4;
   localparam int C_CCC  = 5;

   localparam logic [5:0] CTL_ADDR [NCTL] = '{6'h04, 6'h05, 6'h0F, 6'h20, 6'h21, 6'h22};
   localparam logic [7:0] CTL_RST  [NCTL] = '{8'h00, 8'h01, 8'hF2, 8'h80, 8'h80, 8'h00};

   // one host access as captured at the synchronised strobe start
   typedef struct packed {
      logic       rd;
      logic       dsel;
      logic [7:0] d;
   } acc_t;

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/ctl_ptr.sv
module ctl_ptr #(
   parameter int PTR_W = 6,
   parameter int LAST  = 'h22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PTR_W-1:0] load_val,
   input  logic             step,
   output logic [PTR_W-1:0] ptr
);

   localparam logic [PTR_W-1:0] LAST_P = PTR_W'(LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ptr <= '0;
      else if (load)                 ptr <= load_val;
      else if (step && ptr < LAST_P) ptr <= ptr + 1'b1;
   end

endmodule

// File: rtl/ctl_store.sv
module ctl_store
   import ctl_regbank_pkg::*;
#(
   parameter int         PTR_W = 6,
   parameter logic [7:0] ID0   = 8'h97,
   parameter logic [7:0] ID1   = 8'h24,
   parameter logic [7:0] ID2   = 8'h90,
   parameter logic [7:0] REV   = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [PTR_W-1:0]  rd_addr,
   input  logic              ser_mode,
   input  logic [1:0]        gp_in,
   input  logic              burst_flag,
   input  logic              csync_n,
   input  logic [2:0]        field_id,
   output logic [7:0]        rd_data,
   output logic [NCTL*8-1:0] ctl_flat,
   output logic [3:0]        gp_bits
);

   // control bytes, one per table entry
   for (genvar i = 0; i < NCTL; i++) begin : g_ctl
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= CTL_RST[i];
         else if (wr_en && wr_addr == PTR_W'(CTL_ADDR[i]))
            q <= wr_data;
      end
      assign ctl_flat[i*8 +: 8] = q;
   end

   // only the output field of the general-purpose register is storage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gp_bits <= '0;
      else if (wr_en && wr_addr == PTR_W'(A_GP))
         gp_bits <= wr_data[5:2];
   end

   always_comb begin
      rd_data = 8'h00;
      if (rd_addr == PTR_W'(A_ID0))        rd_data = ID0;
      else if (rd_addr == PTR_W'(A_ID1))   rd_data = ID1;
      else if (rd_addr == PTR_W'(A_ID2))   rd_data = ID2;
      else if (rd_addr == PTR_W'(A_REV))   rd_data = REV;
      else if (rd_addr == PTR_W'(A_FIELD)) rd_data = {2'b00, field_id, 3'b000};
      else if (rd_addr == PTR_W'(A_GP))
         rd_data = {(ser_mode ? gp_in : 2'b00), gp_bits, burst_flag, csync_n};
      for (int i = 0; i < NCTL; i++) begin
         if (rd_addr == PTR_W'(CTL_ADDR[i])) rd_data = ctl_flat[i*8 +: 8];
      end
   end

endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
   import ctl_regbank_pkg::*;
#(
   parameter int         DATA_W      = 8,
   parameter int         PTR_W       = 6,
   parameter int         SYNC_STAGES = 2,
   parameter int         PTR_LAST    = 'h22,
   parameter logic [7:0] ID0         = 8'h97,
   parameter logic [7:0] ID1         = 8'h24,
   parameter logic [7:0] ID2         = 8'h90,
   parameter logic [7:0] REV_ID      = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rw,
   input  logic              a_sel,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   input  logic              ser_mode,
   input  logic [1:0]        gp_in,
   output logic [3:0]        gp_out,
   output logic              gp_out_en,
   input  logic              burst_flag,
   input  logic              csync_n,
   input  logic [2:0]        field_id,
   output logic              out_en,
   output logic [7:0]        glob_ctl,
   output logic [7:0]        vid_ctl,
   output logic [7:0]        gen_ctl,
   output logic [7:0]        cc_byte1,
   output logic [7:0]        cc_byte2,
   output logic [7:0]        cc_ctl
);

   // elaboration-time parameter checks
   if (DATA_W != 8) begin : g_bad_width
      $error("ctl_regbank: register layout is byte wide, DATA_W must be 8");
   end
   if (PTR_W < 6 || PTR_W > DATA_W) begin : g_bad_ptr
      $error("ctl_regbank: PTR_W must cover 3Fh and fit in a data byte");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ctl_regbank: at least two synchroniser stages are required");
   end
   if (PTR_LAST != int'(A_LAST)) begin : g_bad_last
      $error("ctl_regbank: pointer limit must match the last mapped register");
   end

   logic             cs_s, cs_d;
   logic             acc_start, acc_end;
   acc_t             acc_q;
   logic [PTR_W-1:0] ptr;
   logic [7:0]       rd_data;
   logic [NCTL*8-1:0] ctl_flat;
   logic [3:0]       gp_bits;
   logic             wr_en, ptr_load, ptr_step, rd_gp_now;

   ctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cs_n),
      .q     (cs_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d   <= 1'b1;
         out_en <= 1'b0;
      end else begin
         cs_d   <= cs_s;
         out_en <= 1'b1;
      end
   end

   assign acc_start = cs_d & ~cs_s;
   assign acc_end   = ~cs_d & cs_s;

   // strobe qualifiers are stable by the time the synchronised fall arrives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         acc_q <= '0;
      else if (acc_start) acc_q <= '{rd: rw, dsel: a_sel, d: bus_in};
   end

   assign wr_en    = acc_end & ~acc_q.rd &  acc_q.dsel;
   assign ptr_load = acc_end & ~acc_q.rd & ~acc_q.dsel;
   assign ptr_step = acc_end &  acc_q.dsel;

   ctl_ptr #(.PTR_W(PTR_W), .LAST(PTR_LAST)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_load),
      .load_val (acc_q.d[PTR_W-1:0]),
      .step     (ptr_step),
      .ptr      (ptr)
   );

   ctl_store #(
      .PTR_W (PTR_W),
      .ID0   (ID0),
      .ID1   (ID1),
      .ID2   (ID2),
      .REV   (REV_ID)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (ptr),
      .wr_data    (acc_q.d),
      .rd_addr    (ptr),
      .ser_mode   (ser_mode),
      .gp_in      (gp_in),
      .burst_flag (burst_flag),
      .csync_n    (csync_n),
      .field_id   (field_id),
      .rd_data    (rd_data),
      .ctl_flat   (ctl_flat),
      .gp_bits    (gp_bits)
   );

   // host port, driven combinationally while a read strobe is held
   assign bus_oe  = rst_n & out_en & ~cs_n & rw;
   assign bus_out = a_sel ? rd_data : DATA_W'(ptr);

   assign rd_gp_now = ~cs_n & rw & a_sel & (ptr == PTR_W'(A_GP));
   assign gp_out    = gp_bits;
   assign gp_out_en = out_en & (ser_mode | rd_gp_now);

   assign glob_ctl = ctl_flat[C_GLOB*8 +: 8];
   assign vid_ctl  = ctl_flat[C_VID*8  +: 8];
   assign gen_ctl  = ctl_flat[C_GEN*8  +: 8];
   assign cc_byte1 = ctl_flat[C_CC1*8  +: 8];
   assign cc_byte2 = ctl_flat[C_CC2*8  +: 8];
   assign cc_ctl   = ctl_flat[C_CCC*8  +: 8];

endmodule

// File: rtl/ctl_regbank_chk.sv
module ctl_regbank_chk #(
   parameter int PTR_W    = 6,
   parameter int PTR_LAST = 'h22
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n,
   input logic             rw,
   input logic             bus_oe,
   input logic             ser_mode,
   input logic             gp_out_en,
   input logic             out_en,
   input logic             acc_end,
   input logic             acc_dsel,
   input logic [PTR_W-1:0] ptr,
   input logic [7:0]       glob_ctl,
   input logic [7:0]       vid_ctl
);

   localparam logic [PTR_W-1:0] LAST_P = PTR_W'(PTR_LAST);

   // R3
   bus_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> (!cs_n && rw));

   // R2
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_end && acc_dsel && ptr < LAST_P) |=> ptr == PTR_W'($past(ptr) + 1'b1));

   // R2
   ptr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_end && acc_dsel && ptr == LAST_P) |=> ptr == LAST_P);

   // R11
   ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_end |=> ($stable(glob_ctl) && $stable(vid_ctl)));

   // R9
   gp_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_mode && out_en) |-> gp_out_en);

   // R5
   rst_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!out_en && !bus_oe));

endmodule

bind ctl_regbank ctl_regbank_chk #(.PTR_W(PTR_W), .PTR_LAST(PTR_LAST)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .rw        (rw),
   .bus_oe    (bus_oe),
   .ser_mode  (ser_mode),
   .gp_out_en (gp_out_en),
   .out_en    (out_en),
   .acc_end   (acc_end),
   .acc_dsel  (acc_q.dsel),
   .ptr       (ptr),
   .glob_ctl  (glob_ctl),
   .vid_ctl   (vid_ctl)
);

// File: tb/sim_ctl_regbank.sv
module sim_ctl_regbank;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       rw = 1'b0;
   logic       a_sel = 1'b0;
   logic [7:0] bus_in = '0;
   logic [7:0] bus_out;
   logic       bus_oe;
   logic       ser_mode = 1'b0;
   logic [1:0] gp_in = 2'b10;
   logic [3:0] gp_out;
   logic       gp_out_en;
   logic       burst_flag = 1'b1;
   logic       csync_n = 1'b0;
   logic [2:0] field_id = 3'b101;
   logic       out_en;
   logic [7:0] glob_ctl, vid_ctl, gen_ctl, cc_byte1, cc_byte2, cc_ctl;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ctl_regbank #(.SYNC_STAGES(3), .REV_ID(8'h3A)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .a_sel(a_sel),
      .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
      .ser_mode(ser_mode), .gp_in(gp_in), .gp_out(gp_out),
      .gp_out_en(gp_out_en), .burst_flag(burst_flag), .csync_n(csync_n),
      .field_id(field_id), .out_en(out_en), .glob_ctl(glob_ctl),
      .vid_ctl(vid_ctl), .gen_ctl(gen_ctl), .cc_byte1(cc_byte1),
      .cc_byte2(cc_byte2), .cc_ctl(cc_ctl)
   );

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // one complete host strobe; q holds the port byte sampled mid-strobe
   task automatic access(input logic sel, input logic rd, input logic [7:0] d,
                         output logic [7:0] q);
      @(posedge clk); #1;
      a_sel = sel; rw = rd; bus_in = d; cs_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 q = bus_out;
      repeat (6) @(posedge clk);
      #1 cs_n = 1'b1;
      repeat (8) @(posedge clk);
   endtask

   localparam logic [1:0] OP_P = 2'd0;  // pointer load
   localparam logic [1:0] OP_W = 2'd1;  // data write
   localparam logic [1:0] OP_R = 2'd2;  // data read and compare

   // {op, requirement number, byte}; field_id is 101b so 06h reads 28h
   localparam int NV = 37;
   localparam logic [13:0] VEC [NV] = '{
      {OP_P, 4'd1,  8'h00},
      {OP_R, 4'd4,  8'h97},  // R4 identification bytes
      {OP_R, 4'd4,  8'h24},
      {OP_R, 4'd4,  8'h90},
      {OP_R, 4'd4,  8'h3A},  // R4 revision parameter
      {OP_R, 4'd5,  8'h00},  // R5 04h reset
      {OP_R, 4'd5,  8'h01},  // R5 05h reset
      {OP_R, 4'd6,  8'h28},  // R6 field readback
      {OP_R, 4'd7,  8'h00},  // R7 reserved 07h
      {OP_P, 4'd1,  8'h04},
      {OP_W, 4'd1,  8'hA5},
      {OP_W, 4'd1,  8'h3C},
      {OP_W, 4'd6,  8'hFF},  // R6 write to field ignored
      {OP_W, 4'd7,  8'h55},  // R7 write to reserved ignored
      {OP_P, 4'd1,  8'h04},
      {OP_R, 4'd1,  8'hA5},
      {OP_R, 4'd2,  8'h3C},  // R2 step after read
      {OP_R, 4'd6,  8'h28},
      {OP_R, 4'd7,  8'h00},
      {OP_P, 4'd1,  8'h0F},
      {OP_R, 4'd5,  8'hF2},  // R5 0Fh reset
      {OP_P, 4'd1,  8'h0F},
      {OP_W, 4'd1,  8'h1B},
      {OP_P, 4'd1,  8'h0F},
      {OP_R, 4'd1,  8'h1B},
      {OP_P, 4'd1,  8'h1F},
      {OP_W, 4'd7,  8'h77},  // R7 reserved 1Fh write
      {OP_R, 4'd7,  8'h80},  // R7 neighbour 20h untouched
      {OP_R, 4'd5,  8'h80},  // R5 21h reset
      {OP_R, 4'd5,  8'h00},  // R5 22h reset
      {OP_R, 4'd2,  8'h00},  // R2 pointer held at 22h
      {OP_W, 4'd2,  8'h9C},  // R2 write at 22h
      {OP_R, 4'd2,  8'h9C},  // R2 still at 22h
      {OP_P, 4'd7,  8'h10},
      {OP_R, 4'd7,  8'h00},  // R7 reserved 10h
      {OP_P, 4'd7,  8'h2A},
      {OP_R, 4'd7,  8'h00}   // R7 unmapped above 22h
   };

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] q;

      // R5 / R3: outputs held off during reset even with a read strobe present
      cs_n = 1'b0; rw = 1'b1; a_sel = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk({7'b0, out_en}, 8'h00, "R5 out_en in reset");
      chk({7'b0, bus_oe}, 8'h00, "R3 bus_oe in reset");
      cs_n = 1'b1; rw = 1'b0;
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk({7'b0, out_en}, 8'h01, "R5 out_en after reset");
      chk(glob_ctl, 8'h00, "R5 glob_ctl reset");
      chk(vid_ctl,  8'h01, "R5 vid_ctl reset");
      chk(gen_ctl,  8'hF2, "R5 gen_ctl reset");
      chk(cc_byte1, 8'h80, "R5 cc_byte1 reset");
      chk(cc_byte2, 8'h80, "R5 cc_byte2 reset");
      chk(cc_ctl,   8'h00, "R5 cc_ctl reset");
      chk({4'b0, gp_out}, 8'h00, "R5 gp reset");
      chk({7'b0, gp_out_en}, 8'h00, "R9 idle parallel gp_out_en");

      // R3: drive enable follows the strobes, all within one clock period
      @(posedge clk);
      #1 cs_n = 1'b0; rw = 1'b1; a_sel = 1'b0;
      #1 chk({7'b0, bus_oe}, 8'h01, "R3 read strobe");
      rw = 1'b0;
      #1 chk({7'b0, bus_oe}, 8'h00, "R3 write strobe");
      cs_n = 1'b1; rw = 1'b1;
      #1 chk({7'b0, bus_oe}, 8'h00, "R3 deselected");
      rw = 1'b0;
      repeat (8) @(posedge clk);

      // vector table
      for (int i = 0; i < NV; i++) begin
         logic [1:0] op;
         logic [3:0] rq;
         logic [7:0] v;
         op = VEC[i][13:12];
         rq = VEC[i][11:8];
         v  = VEC[i][7:0];
         case (op)
            OP_P: access(1'b0, 1'b0, v, q);
            OP_W: access(1'b1, 1'b0, v, q);
            default: begin
               access(1'b1, 1'b1, 8'h00, q);
               chk(q, v, $sformatf("R%0d vector %0d", rq, i));
            end
         endcase
      end

      // R1: written bytes on the control outputs
      chk(glob_ctl, 8'hA5, "R1 glob_ctl");
      chk(vid_ctl,  8'h3C, "R1 vid_ctl");
      chk(gen_ctl,  8'h1B, "R1 gen_ctl");
      chk(cc_ctl,   8'h9C, "R1 cc_ctl");

      // R1: pointer readback
      access(1'b0, 1'b0, 8'h0E, q);
      access(1'b0, 1'b1, 8'h00, q);
      chk(q, 8'h0E, "R1 pointer readback");

      // R11: write not visible until after the synchronised release
      access(1'b0, 1'b0, 8'h04, q);
      @(posedge clk);
      #1 a_sel = 1'b1; rw = 1'b0; bus_in = 8'h11; cs_n = 1'b0;
      repeat (6) @(posedge clk);
      #1 chk(glob_ctl, 8'hA5, "R11 held during strobe");
      cs_n = 1'b1;
      repeat (2) @(posedge clk);
      #1 chk(glob_ctl, 8'hA5, "R11 held before sync release");
      repeat (6) @(posedge clk);
      #1 chk(glob_ctl, 8'h11, "R11 committed");

      // R8 R9 R10: serial mode general-purpose register
      ser_mode = 1'b1;
      access(1'b0, 1'b0, 8'h0E, q);
      access(1'b1, 1'b0, 8'hFF, q);
      chk({4'b0, gp_out}, 8'h0F, "R9 serial gp_out");
      chk({7'b0, gp_out_en}, 8'h01, "R9 serial gp_out_en");
      access(1'b0, 1'b0, 8'h0E, q);
      access(1'b1, 1'b1, 8'h00, q);
      chk(q, 8'hBE, "R8 R10 serial read 0Eh");
      gp_in = 2'b01; burst_flag = 1'b0; csync_n = 1'b1;
      access(1'b0, 1'b0, 8'h0E, q);
      access(1'b1, 1'b1, 8'h00, q);
      chk(q, 8'h7D, "R8 R10 live pins follow");
      access(1'b0, 1'b0, 8'h0E, q);
      access(1'b1, 1'b0, 8'h00, q);
      chk({4'b0, gp_out}, 8'h00, "R9 gp cleared");
      access(1'b0, 1'b0, 8'h0E, q);
      access(1'b1, 1'b1, 8'h00, q);
      chk(q, 8'h41, "R8 R10 written zeros do not reach live bits");
      access(1'b0, 1'b0, 8'h0E, q);
      access(1'b1, 1'b0, 8'h3C, q);

      // R8 R9: parallel mode
      ser_mode = 1'b0;
      #1 chk({7'b0, gp_out_en}, 8'h00, "R9 parallel idle");
      access(1'b0, 1'b0, 8'h0E, q);
      @(posedge clk);
      #1 a_sel = 1'b1; rw = 1'b1; cs_n = 1'b0;
      #1 chk({7'b0, gp_out_en}, 8'h01, "R9 parallel read drives");
      chk({4'b0, gp_out}, 8'h0F, "R9 parallel gp_out");
      chk(bus_out, 8'h3D, "R8 parallel read masks inputs");
      repeat (6) @(posedge clk);
      #1 cs_n = 1'b1;
      #1 chk({7'b0, gp_out_en}, 8'h00, "R9 parallel release");
      repeat (8) @(posedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule